// File: doc/BRIEF.md
# Blinking GPIO Port

This block is a general-purpose I/O port of up to 32 pins behind a small word-addressed register bus. Software sets, for each pin, a static output level, a direction, an input polarity inversion and a blink enable. It reads the synchronised pin levels back through a read-only register. Any pin configured as an output is driven from its static output bit. If its blink enable is set, the pin is driven instead from one free-running square wave that all blinking pins share.

The port also holds the registers that the interrupt logic next to it needs. One register latches rising edges of the polarity-adjusted input. Two further registers mask the edge-triggered and level-triggered sources. The port presents the masked edge and level sources per pin on two output vectors. Combining those vectors is left to the surrounding interrupt logic.

The two mask registers can be moved away from the other registers by a parameterised byte offset. This lets the same port sit in an address map that groups masks elsewhere.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero, direction register reading all ones over the implemented pins). The output, blink, polarity, edge-cause, edge-mask and level-mask registers all read zero, and both pending vectors are zero.
- R2: The register map uses these byte addresses: static output 0x00, direction 0x04, blink enable 0x08, input polarity 0x0C, data in 0x10 and edge cause 0x14. The edge mask sits at 0x18 plus `MASK_OFS` and the level mask at 0x1C plus `MASK_OFS`. A write takes effect at the clock edge on which `bus_wr` is sampled high. Bit n of a register belongs to pin n. Bits at and above `NUM_PINS` are dropped on write and read as zero.
- R3: A read presents its data on `bus_rdata` in the cycle after `bus_rd` is sampled. `bus_rdata` is zero in every cycle that does not follow a read. A read from any address not listed in R2 returns zero, and that includes 0x18 and 0x1C when `MASK_OFS` is not zero. Writes to data in, or to an unlisted address, change no register.
- R4: `pin_oe[n]` is the inverse of direction bit n: a direction bit of 1 makes the pin an input, and 0 makes it an output.
- R5: While blink bit n is 0, `pin_o[n]` equals static output bit n, starting in the cycle after that bit is written.
- R6: While blink bit n is 1, `pin_o[n]` follows a shared square wave whose level changes every `BLINK_HALF` clock cycles. All blinking pins carry the same level in every cycle.
- R7: The data-in register returns each pin level after a synchroniser of `SYNC_STAGES` flops, XORed with its polarity bit. With two stages, a pin change made before a clock edge is first returned by a read sampled at the third edge.
- R8: An edge-cause bit is set when the polarity-adjusted input of that pin goes from 0 to 1. With polarity 1, that is a falling pin edge. A write to the edge-cause address clears the bits where the written data is 0 and keeps those where it is 1. A new edge in the same cycle as the write wins, and the bit stays set.
- R9: `edge_pend[n]` is edge-cause bit n ANDed with edge-mask bit n. `level_pend[n]` is data-in bit n ANDed with level-mask bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| pin_i | input | NUM_PINS | Asynchronous pin levels from the pads |
| pin_o | output | NUM_PINS | Output level per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| edge_pend | output | NUM_PINS | Masked edge causes, towards the interrupt logic |
| level_pend | output | NUM_PINS | Masked level causes, towards the interrupt logic |

## Verification
The bench builds the port with eight pins, a mask offset of 0x20 and a blink half period of three cycles. Eight pins make the output, direction and data-in sweeps fully exhaustive: every value of each register is written and checked, and every input pattern is checked under four polarity settings. The non-zero mask offset moves the masks to 0x38 and 0x3C. That makes the base mask addresses holes that must read zero, and a full sweep over all 256 bus addresses checks the whole map. The short half period lets a thirty-cycle window hold several blink transitions, so the spacing between transitions can be measured directly.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned BUS_W = 32;

   // byte addresses of the unshifted registers
   localparam int unsigned ADR_OUT   = 'h00;
   localparam int unsigned ADR_DIR   = 'h04;
   localparam int unsigned ADR_BLINK = 'h08;
   localparam int unsigned ADR_POL   = 'h0C;
   localparam int unsigned ADR_DIN   = 'h10;
   localparam int unsigned ADR_CAUSE = 'h14;
   // base addresses of the shiftable mask registers
   localparam int unsigned ADR_EMASK = 'h18;
   localparam int unsigned ADR_LMASK = 'h1C;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_OUT,
      SEL_DIR,
      SEL_BLINK,
      SEL_POL,
      SEL_DIN,
      SEL_CAUSE,
      SEL_EMASK,
      SEL_LMASK
   } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_blink_osc.sv
module gpio_blink_osc #(
   parameter int unsigned HALF = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o,
   output logic wrap_o
);

   generate
      if (HALF == 1) begin : g_every_cycle
         assign wrap_o = 1'b1;
      end else begin : g_counter
         localparam int unsigned CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         assign wrap_o = (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (wrap_o) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= 1'b0;
      end else if (wrap_o) begin
         phase_o <= ~phase_o;
      end
   end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic [NUM_PINS-1:0] out_i,
   input  logic [NUM_PINS-1:0] dir_i,
   input  logic [NUM_PINS-1:0] blink_i,
   input  logic                phase_i,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign pin_o[i]  = blink_i[i] ? phase_i : out_i[i];
      assign pin_oe[i] = ~dir_i[i];
   end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned MASK_OFS = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pins_sync_i,
   output logic [NUM_PINS-1:0] out_o,
   output logic [NUM_PINS-1:0] dir_o,
   output logic [NUM_PINS-1:0] blink_o,
   output logic [NUM_PINS-1:0] edge_pend_o,
   output logic [NUM_PINS-1:0] level_pend_o
);

   localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(ADR_OUT);
   localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(ADR_DIR);
   localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(ADR_BLINK);
   localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(ADR_POL);
   localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(ADR_DIN);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(ADR_CAUSE);
   localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(ADR_EMASK + MASK_OFS);
   localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(ADR_LMASK + MASK_OFS);

   logic [NUM_PINS-1:0] out_q, dir_q, blink_q, pol_q;
   logic [NUM_PINS-1:0] emask_q, lmask_q, cause_q, din_q;
   logic [NUM_PINS-1:0] din, rise, keep, cause_nxt, wval;
   reg_sel_e            sel;
   logic [BUS_W-1:0]    rd_val;

   // address decode shared by reads and writes
   always_comb begin
      sel = SEL_NONE;
      if      (bus_addr == A_OUT)   sel = SEL_OUT;
      else if (bus_addr == A_DIR)   sel = SEL_DIR;
      else if (bus_addr == A_BLINK) sel = SEL_BLINK;
      else if (bus_addr == A_POL)   sel = SEL_POL;
      else if (bus_addr == A_DIN)   sel = SEL_DIN;
      else if (bus_addr == A_CAUSE) sel = SEL_CAUSE;
      else if (bus_addr == A_EMASK) sel = SEL_EMASK;
      else if (bus_addr == A_LMASK) sel = SEL_LMASK;
   end

   assign wval = bus_wdata[NUM_PINS-1:0];
   assign din  = pins_sync_i ^ pol_q;
   assign rise = din & ~din_q;
   assign keep = (bus_wr && sel == SEL_CAUSE) ? wval : '1;
   // a fresh edge wins over a clearing write
   assign cause_nxt = (cause_q & keep) | rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '1;
         blink_q <= '0;
         pol_q   <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else if (bus_wr) begin
         unique case (sel)
            SEL_OUT:   out_q   <= wval;
            SEL_DIR:   dir_q   <= wval;
            SEL_BLINK: blink_q <= wval;
            SEL_POL:   pol_q   <= wval;
            SEL_EMASK: emask_q <= wval;
            SEL_LMASK: lmask_q <= wval;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         din_q   <= '0;
      end else begin
         cause_q <= cause_nxt;
         din_q   <= din;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_OUT:   rd_val = BUS_W'(out_q);
         SEL_DIR:   rd_val = BUS_W'(dir_q);
         SEL_BLINK: rd_val = BUS_W'(blink_q);
         SEL_POL:   rd_val = BUS_W'(pol_q);
         SEL_DIN:   rd_val = BUS_W'(din);
         SEL_CAUSE: rd_val = BUS_W'(cause_q);
         SEL_EMASK: rd_val = BUS_W'(emask_q);
         SEL_LMASK: rd_val = BUS_W'(lmask_q);
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= bus_rd ? rd_val : '0;
      end
   end

   assign out_o        = out_q;
   assign dir_o        = dir_q;
   assign blink_o      = blink_q;
   assign edge_pend_o  = cause_q & emask_q;
   assign level_pend_o = din & lmask_q;

endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned MASK_OFS    = 0,
   parameter int unsigned BLINK_HALF  = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_i,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] edge_pend,
   output logic [NUM_PINS-1:0] level_pend
);

   localparam int unsigned TOP_ADR = ADR_LMASK + MASK_OFS;

   if (NUM_PINS < 1 || NUM_PINS > BUS_W) begin : g_bad_pins
      $error("NUM_PINS must lie between 1 and the bus width");
   end
   if (MASK_OFS % 4 != 0) begin : g_bad_ofs
      $error("MASK_OFS must be word aligned");
   end
   if (TOP_ADR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the shifted mask registers");
   end
   if (BLINK_HALF < 1) begin : g_bad_half
      $error("BLINK_HALF must be at least one cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least two");
   end

   logic [NUM_PINS-1:0] pins_sync;
   logic [NUM_PINS-1:0] out_q, dir_q, blink_q;
   logic                blink_phase, blink_wrap;

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pins_sync)
   );

   gpio_blink_osc #(
      .HALF (BLINK_HALF)
   ) u_osc (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (blink_phase),
      .wrap_o  (blink_wrap)
   );

   gpio_regfile #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .MASK_OFS (MASK_OFS)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pins_sync_i  (pins_sync),
      .out_o        (out_q),
      .dir_o        (dir_q),
      .blink_o      (blink_q),
      .edge_pend_o  (edge_pend),
      .level_pend_o (level_pend)
   );

   gpio_pin_drive #(
      .NUM_PINS (NUM_PINS)
   ) u_drive (
      .out_i   (out_q),
      .dir_i   (dir_q),
      .blink_i (blink_q),
      .phase_i (blink_phase),
      .pin_o   (pin_o),
      .pin_oe  (pin_oe)
   );

endmodule

// File: rtl/gpio_blink_port_chk.sv
module gpio_blink_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned P      = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [P-1:0]      pin_o,
   input logic [P-1:0]      pin_oe,
   input logic [P-1:0]      blink_en,
   input logic              phase,
   input logic              wrap
);

   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(ADR_OUT);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(ADR_DIR);

   logic [P-1:0] blink_drv;
   assign blink_drv = blink_en & pin_oe;

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);  // R3

   AST_DIR_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DIR) |=> pin_oe == ~$past(bus_wdata[P-1:0]));  // R4

   AST_STATIC_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_OUT && blink_en == '0)
      |=> pin_o == $past(bus_wdata[P-1:0]));  // R5

   AST_BLINK_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_o & blink_drv) == '0) || ((pin_o & blink_drv) == blink_drv));  // R6

   AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(phase));  // R6

   AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> phase != $past(phase));  // R6

endmodule

bind gpio_blink_port gpio_blink_port_chk #(
   .P      (NUM_PINS),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_o     (pin_o),
   .pin_oe    (pin_oe),
   .blink_en  (blink_q),
   .phase     (blink_phase),
   .wrap      (blink_wrap)
);

// File: tb/gpio_blink_port_tb_top.sv
module gpio_blink_port_tb_top;

   localparam int unsigned P     = 8;
   localparam int unsigned AW    = 8;
   localparam int unsigned MOFS  = 'h20;
   localparam int unsigned HALF  = 3;

   localparam logic [7:0] A_OUT   = 8'h00;
   localparam logic [7:0] A_DIR   = 8'h04;
   localparam logic [7:0] A_BLINK = 8'h08;
   localparam logic [7:0] A_POL   = 8'h0C;
   localparam logic [7:0] A_DIN   = 8'h10;
   localparam logic [7:0] A_CAUSE = 8'h14;
   localparam logic [7:0] A_EMASK = 8'h38;
   localparam logic [7:0] A_LMASK = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [P-1:0]  pin_i = '0;
   logic [P-1:0]  pin_o, pin_oe, edge_pend, level_pend;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   gpio_blink_port #(
      .NUM_PINS    (P),
      .ADDR_W      (AW),
      .MASK_OFS    (MOFS),
      .BLINK_HALF  (HALF),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pin_i      (pin_i),
      .pin_o      (pin_o),
      .pin_oe     (pin_oe),
      .edge_pend  (edge_pend),
      .level_pend (level_pend)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] map_val(input int a);
      case (a)
         'h00: return 32'h11;
         'h04: return 32'h22;
         'h0C: return 32'h44;
         'h10: return 32'h44;
         'h38: return 32'h55;
         'h3C: return 32'h66;
         default: return 32'h0;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] d1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 oe", 32'(pin_oe), 32'h0);
      check("R1 edge_pend", 32'(edge_pend), 32'h0);
      check("R1 level_pend", 32'(level_pend), 32'h0);
      rd(A_OUT, d);   check("R1 out", d, 32'h0);
      rd(A_DIR, d);   check("R1 dir", d, 32'hFF);
      rd(A_BLINK, d); check("R1 blink", d, 32'h0);
      rd(A_POL, d);   check("R1 pol", d, 32'h0);
      rd(A_CAUSE, d); check("R1 cause", d, 32'h0);
      rd(A_EMASK, d); check("R1 emask", d, 32'h0);
      rd(A_LMASK, d); check("R1 lmask", d, 32'h0);

      // R2 / R5: exhaustive static output sweep
      for (int v = 0; v < 256; v++) begin
         wr(A_OUT, 32'(v));
         check("R5 pin_o follows out", 32'(pin_o), 32'(v));
         rd(A_OUT, d);
         check("R2 out readback", d, 32'(v));
      end
      // R2: bits above NUM_PINS dropped
      wr(A_POL, 32'hFFFF_FF5A);
      rd(A_POL, d);
      check("R2 upper bits zero", d, 32'h5A);

      // R4: exhaustive direction sweep
      for (int v = 0; v < 256; v++) begin
         wr(A_DIR, 32'(v));
         check("R4 oe is inverse dir", 32'(pin_oe), 32'(~v & 'hFF));
         rd(A_DIR, d);
         check("R2 dir readback", d, 32'(v));
      end

      // R3: full address sweep with a known map
      wr(A_OUT, 32'h11); wr(A_DIR, 32'h22); wr(A_BLINK, 32'h0);
      wr(A_POL, 32'h44); wr(A_EMASK, 32'h55); wr(A_LMASK, 32'h66);
      settle();
      wr(A_CAUSE, 32'h0);
      wr(A_DIN, 32'hFF);
      wr(8'h18, 32'hFF);
      wr(8'h1C, 32'hFF);
      wr(8'h40, 32'hFF);
      for (int a = 0; a < 256; a++) begin
         rd(8'(a), d);
         check("R3 address map", d, map_val(a));
      end
      @(negedge clk);
      check("R3 idle rdata zero", bus_rdata, 32'h0);

      // R7: data in = pins xor polarity, exhaustive over pins
      for (int k = 0; k < 4; k++) begin
         logic [7:0] pv;
         pv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h3C;
         wr(A_POL, 32'(pv));
         for (int v = 0; v < 256; v++) begin
            pin_i = 8'(v);
            @(negedge clk); @(negedge clk);
            rd(A_DIN, d);
            check("R7 data in", d, 32'(8'(v) ^ pv));
         end
      end
      // R7: synchroniser latency
      wr(A_POL, 32'h0);
      pin_i = 8'h00;
      settle();
      pin_i = 8'hFF;
      bus_addr = A_DIN; bus_rd = 1'b1;
      @(negedge clk); d = bus_rdata;
      check("R7 latency edge1 old", d, 32'h00);
      @(negedge clk); d = bus_rdata;
      check("R7 latency edge2 old", d, 32'h00);
      @(negedge clk); d = bus_rdata;
      bus_rd = 1'b0;
      check("R7 latency edge3 new", d, 32'hFF);

      // R8 / R9: edge cause and pending vectors
      pin_i = 8'h00;
      settle();
      wr(A_CAUSE, 32'h0);
      wr(A_EMASK, 32'h0F);
      wr(A_LMASK, 32'hF0);
      pin_i = 8'h81;
      settle();
      rd(A_CAUSE, d);
      check("R8 rising sets cause", d, 32'h81);
      check("R9 edge_pend", 32'(edge_pend), 32'h01);
      check("R9 level_pend high", 32'(level_pend), 32'h80);
      pin_i = 8'h00;
      settle();
      rd(A_CAUSE, d);
      check("R8 falling ignored", d, 32'h81);
      check("R9 level_pend low", 32'(level_pend), 32'h00);
      wr(A_CAUSE, 32'h80);
      rd(A_CAUSE, d);
      check("R8 zero bits clear", d, 32'h80);
      check("R9 edge_pend cleared", 32'(edge_pend), 32'h00);
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, d);
      check("R8 all cleared", d, 32'h0);
      // R8: edge wins over a clearing write in the same cycle
      pin_i = 8'h02;
      @(negedge clk); @(negedge clk);
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, d);
      check("R8 set beats clear", d, 32'h02);
      // R8: falling pin edge caught with polarity set
      pin_i = 8'h04;
      settle();
      wr(A_POL, 32'h04);
      settle();
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, d1);
      check("R8 no edge after clear", d1, 32'h0);
      pin_i = 8'h00;
      settle();
      rd(A_CAUSE, d);
      check("R8 inverted falling edge", d, 32'h04);
      wr(A_POL, 32'h0);

      // R6: blink spacing and phase alignment
      wr(A_DIR, 32'h00);
      wr(A_OUT, 32'h0F);
      wr(A_BLINK, 32'h3C);
      check("R4 all outputs", 32'(pin_oe), 32'hFF);
      begin
         int  last_chg;
         int  seen;
         logic prev;
         last_chg = -1; seen = 0;
         prev = pin_o[2];
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            check("R6 blinking pins equal", 32'((pin_o >> 2) & 8'h0F),
                  pin_o[2] ? 32'h0F : 32'h00);
            check("R5 static pins hold", 32'(pin_o & 8'hC3), 32'h03);
            if (pin_o[2] != prev) begin
               if (last_chg >= 0) check("R6 half period", 32'(c - last_chg), 32'(HALF));
               last_chg = c;
               seen++;
            end
            prev = pin_o[2];
         end
         check("R6 transitions seen", 32'(seen >= 8), 32'h1);
      end
      wr(A_DIR, 32'h3C);
      check("R4 blink pins as inputs", 32'(pin_oe), 32'hC3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule